// File: doc/BRIEF.md
# Configuration Register Target with Nonvolatile Shadow

This block is a two-wire serial (I2C) target that holds six configuration registers and one control register. Each configuration register has a nonvolatile shadow. When the block leaves reset, the shadow contents are loaded into the working registers. The working registers drive the configuration outputs directly.

A bus controller writes or reads one register, or several in a burst. The register pointer steps up by one after each byte. Bit 0 of the control register picks the source for reads: the working registers or their shadows. Bit 7 of the control register requests a bulk save. At the next STOP the working values are copied into the shadow, and a busy window of `SAVE_CYCLES` clocks begins. A controller that addresses the target inside that window has SCL held low after its address byte until the window ends.

The shadow array is a plain flop array with its own power-on reset, `por_n`, which restores the factory values. The ordinary reset, `rst_n`, only reloads the working registers from the shadow.

Top module: `cfg_i2c_nvregs`

## Requirements
- R1: The target acknowledges the address byte 58h (write) and 59h (read), that is, 7-bit address 2Ch. For any other address it leaves SDA released in the acknowledge slot.
- R2: After power-on reset, the working registers at A0h..A5h read 01h, 05h, 03h, 01h, 00h, 00h, and the control register at FFh reads 00h.
- R3: Only these bits are stored: A0h bits [1:0], A1h bits [3:0], A2h bits [2:0], A3h bits [1:0], A4h bits [1:0], A5h bit [0]. All other bits of these registers ignore writes and read as 0.
- R4: In a burst write or a burst read, the register pointer moves to the next higher address after every data byte.
- R5: Control bit 0 selects the read source: 0 returns the working registers and 1 returns the shadow copies. Ordinary register writes leave the shadow unchanged.
- R6: Writing a byte with bit 7 set to FFh copies all six working registers into the shadow at the next STOP. A busy window of SAVE_CYCLES clocks then starts, and control bit 7 reads 1 until the window closes and 0 afterwards.
- R7: Pulsing `rst_n` reloads the working registers from the shadow. Pulsing `por_n` restores the factory values to both the shadow and the working registers.
- R8: A controller that addresses the target during the busy window has SCL held low from the end of its address byte until the window closes. The target then acknowledges.
- R9: A read is a pointer write, then a repeated START with 59h. Bytes are returned until the controller answers NACK. After the NACK the target keeps SDA released.
- R10: Addresses other than A0h..A5h and FFh are acknowledged. Writes to them have no effect, and reads from them return 00h.
- R11: The configuration outputs equal the stored fields of the working registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; reloads working registers from the shadow |
| por_n | input | 1 | Active-low power-on reset; restores factory values everywhere |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_pull_o | output | 1 | Pull SCL low (clock stretch) |
| sda_pull_o | output | 1 | Pull SDA low (acknowledge or data 0) |
| dim_mode_o | output | 2 | Dimming method field (A0h) |
| sink_code_o | output | 4 | Full-scale sink current code (A1h) |
| uvlo_code_o | output | 3 | Input undervoltage threshold code (A2h) |
| fsw_code_o | output | 2 | Switching frequency code (A3h) |
| slew_code_o | output | 2 | Switch slew-rate code (A4h) |
| ilim_sd_o | output | 1 | Current-limit shutdown enable (A5h) |

## Verification
A register pointer that steps wrongly shows up within the same burst: the second byte read back is out of order. Bad masking shows up on the next read and on the outputs in the cycle after the write. A save machine that copies at the wrong moment, or never, shows up only when the shadow is read through control bit 0 or reloaded by `rst_n`, so the bench does both after every save. A wrong busy window shows up as a stretch that is too long or too short, measured from the STOP to the moment SCL is released.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
   typedef logic [7:0] byte_t;

   localparam int    NUM_CFG      = 6;
   localparam byte_t CFG_BASE     = 8'hA0;
   localparam byte_t CTL_ADDR     = 8'hFF;
   localparam int    CTL_SRC_BIT  = 0;
   localparam int    CTL_SAVE_BIT = 7;
   localparam int    FIELD_BITS   = 14;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_HOLD, ST_AACK, ST_PTR,
      ST_PACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
   } tgt_state_e;

   // stored-bit mask per configuration slot
   function automatic byte_t cfg_mask(input int idx);
      case (idx)
         0:       return 8'h03;
         1:       return 8'h0F;
         2:       return 8'h07;
         3:       return 8'h03;
         4:       return 8'h03;
         default: return 8'h01;
      endcase
   endfunction

   // factory value per configuration slot
   function automatic byte_t cfg_factory(input int idx);
      case (idx)
         0:       return 8'h01;
         1:       return 8'h05;
         2:       return 8'h03;
         3:       return 8'h01;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int TOP = STAGES - 1;

   logic [TOP:0] scl_q, sda_q;
   logic         scl_d, sda_d, scl_s;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_q <= {scl_q[TOP-1:0], scl_i};
         sda_q <= {sda_q[TOP-1:0], sda_i};
         scl_d <= scl_q[TOP];
         sda_d <= sda_q[TOP];
      end
   end

   assign scl_s     = scl_q[TOP];
   assign sda_s     = sda_q[TOP];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import cfgi2c_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR = 7'h2C
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sda_s,
   input  logic  scl_rise,
   input  logic  scl_fall,
   input  logic  start_det,
   input  logic  stop_det,
   input  logic  busy,
   input  byte_t rd_data,
   output byte_t ptr,
   output logic  wr_en,
   output byte_t wr_data,
   output logic  sda_pull,
   output logic  scl_pull
);
   tgt_state_e state;
   logic [3:0] cnt;
   byte_t      shreg, txbyte;
   logic       rw, nack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE; cnt <= '0; shreg <= '0; txbyte <= '0;
         ptr <= '0; rw <= 1'b0; nack <= 1'b0; wr_en <= 1'b0;
         wr_data <= '0; sda_pull <= 1'b0; scl_pull <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state <= ST_ADDR; cnt <= '0; sda_pull <= 1'b0; scl_pull <= 1'b0;
         end else if (stop_det) begin
            state <= ST_IDLE; sda_pull <= 1'b0; scl_pull <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_PTR, ST_WDAT: begin
                  if (scl_rise) begin
                     shreg <= {shreg[6:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     cnt <= '0;
                     if (state == ST_ADDR) begin
                        if (shreg[7:1] == TGT_ADDR) begin
                           rw <= shreg[0];
                           if (busy) begin
                              scl_pull <= 1'b1; state <= ST_HOLD;
                           end else begin
                              sda_pull <= 1'b1; state <= ST_AACK;
                           end
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_PTR) begin
                        ptr <= shreg; sda_pull <= 1'b1; state <= ST_PACK;
                     end else begin
                        wr_en <= 1'b1; wr_data <= shreg;
                        sda_pull <= 1'b1; state <= ST_WACK;
                     end
                  end
               end
               ST_HOLD: if (!busy) begin
                  scl_pull <= 1'b0; sda_pull <= 1'b1; state <= ST_AACK;
               end
               ST_AACK: if (scl_fall) begin
                  cnt <= '0;
                  if (rw) begin
                     txbyte <= rd_data; sda_pull <= ~rd_data[7]; state <= ST_RDAT;
                  end else begin
                     sda_pull <= 1'b0; state <= ST_PTR;
                  end
               end
               ST_PACK: if (scl_fall) begin
                  sda_pull <= 1'b0; state <= ST_WDAT;
               end
               ST_WACK: if (scl_fall) begin
                  sda_pull <= 1'b0; ptr <= ptr + 8'd1; state <= ST_WDAT;
               end
               ST_RDAT: begin
                  if (scl_rise) begin
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        sda_pull <= 1'b0; ptr <= ptr + 8'd1; cnt <= '0; state <= ST_RACK;
                     end else begin
                        sda_pull <= ~txbyte[3'd7 - cnt[2:0]];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     nack <= sda_s;
                  end else if (scl_fall) begin
                     if (!nack) begin
                        txbyte <= rd_data; sda_pull <= ~rd_data[7]; state <= ST_RDAT;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // stretching may only begin while a save is running
   assert_stretch_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_pull) |-> busy);
   // stretching ends one cycle after the save window closes
   assert_stretch_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_pull && !busy && !start_det && !stop_det) |=> !scl_pull);
   // a foreign address byte never gets an acknowledge
   assert_foreign_noack_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR && scl_fall && cnt == 4'd8 && shreg[7:1] != TGT_ADDR
       && !start_det && !stop_det) |=> !sda_pull);
   // after a NACK in the read acknowledge slot, SDA stays released
   assert_nack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RACK && nack && scl_fall && !start_det && !stop_det) |=> !sda_pull);
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
   import cfgi2c_pkg::*;
#(
   parameter int SAVE_CYCLES = 6_250_000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  por_n,
   input  logic  wr_en,
   input  byte_t addr,
   input  byte_t wr_data,
   input  logic  stop_det,
   output byte_t rd_data,
   output logic  busy,
   output logic [FIELD_BITS-1:0] fields_o
);
   localparam int CW = $clog2(SAVE_CYCLES + 1);

   logic [NUM_CFG-1:0][7:0] work, nv;
   logic          rd_src, save_req, reload, save_go;
   logic [CW-1:0] tmr;

   if (SAVE_CYCLES < 1) begin : g_bad_save
      $error("SAVE_CYCLES must be at least one");
   end

   assign save_go = stop_det & save_req & ~busy;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         for (int k = 0; k < NUM_CFG; k++) nv[k] <= cfg_factory(k);
      end else if (save_go) begin
         nv <= work;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_CFG; k++) work[k] <= cfg_factory(k);
         reload <= 1'b1; rd_src <= 1'b0; save_req <= 1'b0;
         busy <= 1'b0; tmr <= '0;
      end else begin
         reload <= 1'b0;
         if (reload) begin
            work <= nv;
         end else if (wr_en) begin
            for (int k = 0; k < NUM_CFG; k++)
               if (addr == CFG_BASE + 8'(k)) work[k] <= wr_data & cfg_mask(k);
            if (addr == CTL_ADDR) begin
               rd_src <= wr_data[CTL_SRC_BIT];
               if (!busy) save_req <= wr_data[CTL_SAVE_BIT];
            end
         end
         if (save_go) begin
            busy <= 1'b1;
            tmr  <= CW'(SAVE_CYCLES - 1);
         end else if (busy) begin
            if (tmr == '0) begin
               busy <= 1'b0; save_req <= 1'b0;
            end else begin
               tmr <= tmr - 1'b1;
            end
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_CFG; k++)
         if (addr == CFG_BASE + 8'(k)) rd_data = rd_src ? nv[k] : work[k];
      if (addr == CTL_ADDR) rd_data = {save_req, 6'b0, rd_src};
   end

   assign fields_o = {work[5][0], work[4][1:0], work[3][1:0],
                      work[2][2:0], work[1][3:0], work[0][1:0]};

   // shadow changes only when a save is launched
   assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      !save_go |=> $stable(nv));
   // a save window opens only right after a STOP
   assert_save_at_stop_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $rose(busy) |-> $past(stop_det));
   // the save request stays visible for the whole window
   assert_req_in_window_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      busy |-> save_req);
endmodule

// File: rtl/cfg_i2c_nvregs.sv
module cfg_i2c_nvregs
   import cfgi2c_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR    = 7'h2C,
   parameter int         SAVE_CYCLES = 6_250_000,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       por_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       scl_pull_o,
   output logic       sda_pull_o,
   output logic [1:0] dim_mode_o,
   output logic [3:0] sink_code_o,
   output logic [2:0] uvlo_code_o,
   output logic [1:0] fsw_code_o,
   output logic [1:0] slew_code_o,
   output logic       ilim_sd_o
);
   logic  run_rst_n, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic  wr_en, busy;
   byte_t ptr, wr_data, rd_data;
   logic [FIELD_BITS-1:0] fields;

   assign run_rst_n = rst_n & por_n;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(run_rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   i2c_tgt_engine #(.TGT_ADDR(TGT_ADDR)) u_engine (
      .clk(clk), .rst_n(run_rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .busy(busy), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
      .wr_data(wr_data), .sda_pull(sda_pull_o), .scl_pull(scl_pull_o));

   cfg_regbank #(.SAVE_CYCLES(SAVE_CYCLES)) u_bank (
      .clk(clk), .rst_n(run_rst_n), .por_n(por_n), .wr_en(wr_en),
      .addr(ptr), .wr_data(wr_data), .stop_det(stop_det),
      .rd_data(rd_data), .busy(busy), .fields_o(fields));

   assign {ilim_sd_o, slew_code_o, fsw_code_o, uvlo_code_o, sink_code_o, dim_mode_o} = fields;
endmodule

// File: tb/cfg_i2c_nvregs_tb.sv
module cfg_i2c_nvregs_tb;
   localparam int SAVE = 3000;
   localparam int Q    = 8;

   logic clk = 1'b0, rst_n = 1'b0, por_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic scl_pull_o, sda_pull_o, ilim_sd_o;
   logic [1:0] dim_mode_o, fsw_code_o, slew_code_o;
   logic [3:0] sink_code_o;
   logic [2:0] uvlo_code_o;
   wire scl_line = scl_m & ~scl_pull_o;
   wire sda_line = sda_m & ~sda_pull_o;

   int checks = 0, fails = 0, cyc = 0, rel_cyc = 0;
   logic [7:0] wbuf [8];
   logic [7:0] rbuf [8];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cfg_i2c_nvregs #(.SAVE_CYCLES(SAVE)) u_dut (
      .clk(clk), .rst_n(rst_n), .por_n(por_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o), .dim_mode_o(dim_mode_o),
      .sink_code_o(sink_code_o), .uvlo_code_o(uvlo_code_o), .fsw_code_o(fsw_code_o),
      .slew_code_o(slew_code_o), .ilim_sd_o(ilim_sd_o));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic raise_scl();
      scl_m = 1'b1;
      while (!scl_line) @(negedge clk);
      rel_cyc = cyc;
   endtask

   task automatic wbit(input logic b);
      sda_m = b; tick(Q); raise_scl(); tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic rbit(output logic b);
      sda_m = 1'b1; tick(Q); raise_scl(); tick(Q); b = sda_line; scl_m = 1'b0; tick(Q);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; tick(Q); raise_scl(); tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; tick(Q); raise_scl(); tick(Q); sda_m = 1'b1; tick(Q);
   endtask

   task automatic wbyte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) wbit(d[i]);
      rbit(b);
      ack = ~b;
   endtask

   task automatic rbyte(output logic [7:0] d, input logic last);
      logic b;
      for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
      wbit(last);
   endtask

   task automatic write_regs(input logic [7:0] a, input int n);
      logic ack;
      i2c_start();
      wbyte(8'h58, ack); wbyte(a, ack);
      for (int i = 0; i < n; i++) wbyte(wbuf[i], ack);
      i2c_stop();
      tick(4);
   endtask

   task automatic read_regs(input logic [7:0] a, input int n);
      logic ack;
      i2c_start();
      wbyte(8'h58, ack); wbyte(a, ack);
      i2c_start();
      wbyte(8'h59, ack);
      for (int i = 0; i < n; i++) rbyte(rbuf[i], i == n - 1);
      tick(4);
      chk("R9 sda released after NACK", sda_pull_o, 0);
      i2c_stop();
      tick(4);
   endtask

   task automatic t_reset();
      chk("R2/R11 dim_mode", dim_mode_o, 1);
      chk("R2/R11 sink_code", sink_code_o, 5);
      chk("R2/R11 uvlo_code", uvlo_code_o, 3);
      chk("R2/R11 fsw_code", fsw_code_o, 1);
      chk("R2/R11 slew_code", slew_code_o, 0);
      chk("R2/R11 ilim_sd", ilim_sd_o, 0);
      read_regs(8'hA0, 6);
      chk("R2 A0", rbuf[0], 8'h01); chk("R2 A1", rbuf[1], 8'h05);
      chk("R2 A2", rbuf[2], 8'h03); chk("R4 R2 A3", rbuf[3], 8'h01);
      chk("R2 A4", rbuf[4], 8'h00); chk("R2 A5", rbuf[5], 8'h00);
      read_regs(8'hFF, 1);
      chk("R2 control", rbuf[0], 8'h00);
   endtask

   task automatic t_foreign_addr();
      logic ack;
      i2c_start(); wbyte(8'h5A, ack); i2c_stop(); tick(4);
      chk("R1 foreign address not acknowledged", ack, 0);
      i2c_start(); wbyte(8'h58, ack); i2c_stop(); tick(4);
      chk("R1 own address acknowledged", ack, 1);
   endtask

   task automatic t_field_mask();
      wbuf[0] = 8'hFF; write_regs(8'hA1, 1);
      chk("R11 sink_code after write", sink_code_o, 4'hF);
      read_regs(8'hA1, 1);
      chk("R3 A1 reserved bits read 0", rbuf[0], 8'h0F);
   endtask

   task automatic t_burst();
      wbuf[0] = 8'hFE; wbuf[1] = 8'h3A; wbuf[2] = 8'hFF;
      wbuf[3] = 8'hF2; wbuf[4] = 8'hF1; wbuf[5] = 8'hFF;
      write_regs(8'hA0, 6);
      read_regs(8'hA0, 6);
      chk("R4 R3 A0", rbuf[0], 8'h02); chk("R4 R3 A1", rbuf[1], 8'h0A);
      chk("R4 R3 A2", rbuf[2], 8'h07); chk("R4 R3 A3", rbuf[3], 8'h02);
      chk("R4 R3 A4", rbuf[4], 8'h01); chk("R4 R3 A5", rbuf[5], 8'h01);
      chk("R11 outputs", {ilim_sd_o, slew_code_o, fsw_code_o, uvlo_code_o, sink_code_o, dim_mode_o},
          {1'b1, 2'd1, 2'd2, 3'd7, 4'hA, 2'd2});
   endtask

   task automatic t_unmapped();
      logic ack;
      i2c_start(); wbyte(8'h58, ack); chk("R10 ack", ack, 1);
      wbyte(8'h10, ack); chk("R10 pointer ack", ack, 1);
      wbyte(8'h55, ack); chk("R10 data ack", ack, 1);
      i2c_stop(); tick(4);
      read_regs(8'h10, 1);
      chk("R10 unmapped reads 00", rbuf[0], 8'h00);
      read_regs(8'hA0, 1);
      chk("R10 A0 untouched", rbuf[0], 8'h02);
   endtask

   task automatic t_read_source(input logic [7:0] e0, input logic [7:0] e1, input string tag);
      wbuf[0] = 8'h01; write_regs(8'hFF, 1);
      read_regs(8'hA0, 2);
      chk({"R5 shadow A0 ", tag}, rbuf[0], e0);
      chk({"R5 shadow A1 ", tag}, rbuf[1], e1);
      wbuf[0] = 8'h00; write_regs(8'hFF, 1);
      read_regs(8'hA0, 1);
      chk("R5 working source restored", rbuf[0], 8'h02);
   endtask

   task automatic t_save_stretch();
      logic ack;
      int   t_stop;
      i2c_start(); wbyte(8'h58, ack); wbyte(8'hFF, ack); wbyte(8'h80, ack);
      i2c_stop();
      t_stop = cyc;
      i2c_start();
      wbyte(8'h58, ack);
      chk("R8 acknowledged after stretch", ack, 1);
      checks++;
      if (rel_cyc - t_stop < SAVE - 30 || rel_cyc - t_stop > SAVE + 30) begin
         fails++;
         $display("FAIL R6 R8 stretch length actual %0d expected %0d", rel_cyc - t_stop, SAVE);
      end
      i2c_stop(); tick(4);
      read_regs(8'hFF, 1);
      chk("R6 save bit cleared", rbuf[0], 8'h00);
   endtask

   task automatic t_reload();
      wbuf[0] = 8'h03; write_regs(8'hA0, 1);
      chk("R11 dim_mode before reset", dim_mode_o, 3);
      tick(2); rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(4);
      chk("R7 reload dim_mode", dim_mode_o, 2);
      chk("R7 reload sink_code", sink_code_o, 4'hA);
      chk("R7 reload ilim_sd", ilim_sd_o, 1);
      por_n = 1'b0; tick(3); por_n = 1'b1; tick(4);
      chk("R7 factory dim_mode", dim_mode_o, 1);
      chk("R7 factory sink_code", sink_code_o, 5);
      read_regs(8'hA0, 1);
      chk("R7 factory A0", rbuf[0], 8'h01);
   endtask

   initial begin
      tick(3); por_n = 1'b1; rst_n = 1'b1; tick(4);
      t_reset();
      t_foreign_addr();
      t_field_mask();
      t_burst();
      t_unmapped();
      t_read_source(8'h01, 8'h05, "before save");
      t_save_stretch();
      t_read_source(8'h02, 8'h0A, "after save");
      t_reload();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual %0d expected below %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule